// File: doc/BRIEF.md
# Command-Launched Serial Flash Read Sequencer

This block fetches a software-chosen number of bytes from an external serial flash into an on-chip receive FIFO. Software first loads a target register holding the flash address, the device select and the access mode. Nothing moves until software writes the command register with a byte count. That write copies the target into a transfer register and opens the transaction.

During the transaction the block raises a byte request toward the flash side whenever the FIFO has room. Every byte the flash side returns while the request is high is stored in arrival order. When the programmed count has been stored, the block stops requesting and returns to idle. Any programming still running inside the flash device is not tracked.

A command-access flag marks a running command read and drives the shared busy output. Software may empty the receive buffer with a clear strobe while the block is idle. The host drains the FIFO through a pop port that shows the head byte before the pop.

Top module: `flash_cmd_reader`

## Requirements
- R1: Writing the target register alone never raises busy or the flash request.
- R2: A command write while idle with a count from 1 to MAX_LEN raises busy in the next cycle. From that cycle on, fl_addr, fl_dev and fl_mode show the target register value held just before the command edge. They stay unchanged until the transaction ends, even if the target register is rewritten.
- R3: cmd_acc is high exactly while a command read runs, and busy equals cmd_acc. Both fall in the cycle after the last requested byte is accepted.
- R4: A byte is accepted on a clock edge where fl_req and fl_valid are both high. Exactly the requested count is accepted, and the bytes are stored in arrival order.
- R5: A clear strobe while idle empties the FIFO (rx_level 0) from the next cycle. If pop arrives in the same cycle, the clear wins.
- R6: A clear strobe while busy leaves the FIFO contents and rx_level unchanged.
- R7: A command with a count of 0 or above MAX_LEN is a no-op and never raises busy.
- R8: A command write while busy does not change the running transfer. It sets cmd_err, which stays set until reset.
- R9: fl_req is low whenever the FIFO holds DEPTH bytes. The transfer resumes after pops, and no byte is lost.
- R10: pop_data shows the oldest stored byte, and a pop removes it. A pop while the FIFO is empty has no effect.
- R11: After reset the block is idle: busy, cmd_acc, cmd_err and fl_req are 0, and rx_level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tgt_wr | input | 1 | Write strobe for the target register |
| tgt_addr | input | ADDR_W | Flash byte address to load |
| tgt_dev | input | DEV_W | Device select to load |
| tgt_mode | input | MODE_W | Access mode to load |
| cmd_wr | input | 1 | Command write strobe; launches the read |
| cmd_len | input | LEN_W | Byte count for the command |
| clr_wr | input | 1 | Self-clearing receive-buffer clear strobe |
| busy | output | 1 | Shared busy indication |
| cmd_acc | output | 1 | Command-access flag |
| cmd_err | output | 1 | Sticky flag for a command written while busy |
| rx_level | output | LVL_W | Bytes held in the receive FIFO |
| pop | input | 1 | Remove the head byte |
| pop_data | output | 8 | Head byte of the receive FIFO |
| fl_req | output | 1 | Byte request toward the flash side |
| fl_valid | input | 1 | Flash side returns a byte |
| fl_data | input | 8 | Returned byte |
| fl_addr | output | ADDR_W | Start address of the running transfer |
| fl_dev | output | DEV_W | Device select of the running transfer |
| fl_mode | output | MODE_W | Access mode of the running transfer |

## Verification
The sequencer is first driven with the flash side answering every request at once. This shows whether the count stops exactly on the last byte. It is then driven with a stalling flash side, which separates counting accepted bytes from counting request cycles. A transfer that starts with the FIFO already partly full forces the request to pause at DEPTH and resume as the host pops; this exposes lost or duplicated bytes. Out-of-range counts, commands while busy, clears while busy, clear together with pop, and target rewrites during a transfer each probe one rule, and a reference queue model is compared against the outputs every cycle.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;
    localparam int ADDR_W = 24;
    localparam int DEV_W  = 2;
    localparam int MODE_W = 3;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DEV_W-1:0]  dev;
        logic [MODE_W-1:0] mode;
    } flash_tgt_t;
endpackage

// File: rtl/flash_rd_fifo.sv
module flash_rd_fifo #(
    parameter int DEPTH = 64,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [7:0]       push_data,
    input  logic             pop,
    output logic [7:0]       head,
    output logic [LVL_W-1:0] level,
    output logic             full
);
    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [LVL_W-1:0] lvl;
    } fifo_st_t;

    fifo_st_t   st_q, st_d;
    logic [7:0] mem_q [DEPTH];
    logic       pop_ok;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign pop_ok = pop && (st_q.lvl != '0);
    assign head   = mem_q[st_q.rp];
    assign level  = st_q.lvl;
    assign full   = (st_q.lvl == LVL_W'(DEPTH));

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            if (push)   st_d.wp = bump(st_q.wp);
            if (pop_ok) st_d.rp = bump(st_q.rp);
            case ({push, pop_ok})
                2'b10:   st_d.lvl = st_q.lvl + 1'b1;
                2'b01:   st_d.lvl = st_q.lvl - 1'b1;
                default: st_d.lvl = st_q.lvl;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push && !clr) mem_q[st_q.wp] <= push_data;
    end

    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (st_q.lvl != LVL_W'(DEPTH)));
    a_r10_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.lvl == '0 && !push) |=> (st_q.lvl == '0));
    a_r5_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (level == '0));
endmodule

// File: rtl/flash_rd_seq.sv
module flash_rd_seq
    import flash_rd_pkg::*;
#(
    parameter int MAX_LEN = 64,
    localparam int LEN_W = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tgt_wr,
    input  flash_tgt_t       tgt_in,
    input  logic             cmd_wr,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic             clr_wr,
    input  logic             fifo_full,
    input  logic             fl_valid,
    output logic             fl_req,
    output logic             take,
    output logic             fifo_clr,
    output logic             acc,
    output logic             err,
    output flash_tgt_t       xfer
);
    typedef struct packed {
        logic             busy;
        logic             err;
        logic [LEN_W-1:0] remain;
        flash_tgt_t       shadow;
        flash_tgt_t       xt;
    } seq_st_t;

    seq_st_t st_q, st_d;
    logic    len_ok;

    assign len_ok   = (cmd_len != '0) && (int'(cmd_len) <= MAX_LEN);
    assign fl_req   = st_q.busy && !fifo_full;
    assign take     = fl_req && fl_valid;
    assign fifo_clr = clr_wr && !st_q.busy;
    assign acc      = st_q.busy;
    assign err      = st_q.err;
    assign xfer     = st_q.xt;

    always_comb begin
        st_d = st_q;
        if (tgt_wr) st_d.shadow = tgt_in;
        if (cmd_wr) begin
            if (st_q.busy) begin
                st_d.err = 1'b1;
            end else if (len_ok) begin
                st_d.busy   = 1'b1;
                st_d.remain = cmd_len;
                st_d.xt     = st_q.shadow;
            end
        end
        if (take) begin
            st_d.remain = st_q.remain - 1'b1;
            if (st_q.remain == LEN_W'(1)) st_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r1_no_self_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc && !cmd_wr) |=> !acc);
    a_r7_bad_len_noop: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc && cmd_wr && !len_ok) |=> !acc);
    a_r2_target_held: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> $stable(xfer));
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    a_r3_ends_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        (take && st_q.remain == LEN_W'(1)) |=> !acc);
endmodule

// File: rtl/flash_cmd_reader.sv
module flash_cmd_reader
    import flash_rd_pkg::*;
#(
    parameter int MAX_LEN = 64,
    parameter int DEPTH   = 64,
    localparam int LEN_W  = $clog2(MAX_LEN + 1),
    localparam int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tgt_wr,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [DEV_W-1:0]  tgt_dev,
    input  logic [MODE_W-1:0] tgt_mode,
    input  logic              cmd_wr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              clr_wr,
    output logic              busy,
    output logic              cmd_acc,
    output logic              cmd_err,
    output logic [LVL_W-1:0]  rx_level,
    input  logic              pop,
    output logic [7:0]        pop_data,
    output logic              fl_req,
    input  logic              fl_valid,
    input  logic [7:0]        fl_data,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DEV_W-1:0]  fl_dev,
    output logic [MODE_W-1:0] fl_mode
);
    flash_tgt_t tgt_in, xfer;
    logic       take, fifo_clr, fifo_full;

    assign tgt_in = '{addr: tgt_addr, dev: tgt_dev, mode: tgt_mode};

    flash_rd_seq #(.MAX_LEN(MAX_LEN)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .tgt_wr(tgt_wr), .tgt_in(tgt_in),
        .cmd_wr(cmd_wr), .cmd_len(cmd_len), .clr_wr(clr_wr),
        .fifo_full(fifo_full), .fl_valid(fl_valid),
        .fl_req(fl_req), .take(take), .fifo_clr(fifo_clr),
        .acc(cmd_acc), .err(cmd_err), .xfer(xfer)
    );

    flash_rd_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .clr(fifo_clr), .push(take), .push_data(fl_data),
        .pop(pop), .head(pop_data), .level(rx_level), .full(fifo_full)
    );

    // Only one access source exists here; busy is the OR of all sources.
    assign busy    = cmd_acc;
    assign fl_addr = xfer.addr;
    assign fl_dev  = xfer.dev;
    assign fl_mode = xfer.mode;

    a_r6_clear_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && clr_wr && !pop) |=> (rx_level >= $past(rx_level)));
endmodule

// File: tb/flash_cmd_reader_test.sv
`timescale 1ns/1ps
module flash_cmd_reader_test;
    localparam int MAX_LEN = 64;
    localparam int DEPTH   = 64;
    localparam int LEN_W   = $clog2(MAX_LEN + 1);
    localparam int LVL_W   = $clog2(DEPTH + 1);

    logic clk = 1'b0, rst_n = 1'b0;
    logic tgt_wr = 0, cmd_wr = 0, clr_wr = 0, pop = 0, fl_valid = 0;
    logic [23:0] tgt_addr = '0;
    logic [1:0]  tgt_dev = '0;
    logic [2:0]  tgt_mode = '0;
    logic [LEN_W-1:0] cmd_len = '0;
    logic [7:0] fl_data = '0;
    logic busy, cmd_acc, cmd_err, fl_req;
    logic [LVL_W-1:0] rx_level;
    logic [7:0] pop_data;
    logic [23:0] fl_addr;
    logic [1:0] fl_dev;
    logic [2:0] fl_mode;

    always #4 clk = ~clk;

    flash_cmd_reader #(.MAX_LEN(MAX_LEN), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .tgt_wr(tgt_wr), .tgt_addr(tgt_addr),
        .tgt_dev(tgt_dev), .tgt_mode(tgt_mode), .cmd_wr(cmd_wr),
        .cmd_len(cmd_len), .clr_wr(clr_wr), .busy(busy), .cmd_acc(cmd_acc),
        .cmd_err(cmd_err), .rx_level(rx_level), .pop(pop), .pop_data(pop_data),
        .fl_req(fl_req), .fl_valid(fl_valid), .fl_data(fl_data),
        .fl_addr(fl_addr), .fl_dev(fl_dev), .fl_mode(fl_mode)
    );

    int n_cmp = 0, n_bad = 0, cyc_n = 0;
    string ph = "R11";

    // reference model
    bit m_busy = 0, m_err = 0;
    int m_remain = 0;
    logic [7:0] m_q[$];
    logic [28:0] m_sh = '0, m_xt = '0;
    logic [7:0] nxt_byte = 8'h40;

    // stimulus for the next tick
    bit d_tgt = 0, d_cmd = 0, d_clr = 0, pop_hold = 0, stall = 0;
    logic [23:0] d_addr = '0;
    logic [1:0]  d_dev = '0;
    logic [2:0]  d_mode = '0;
    int d_len = 0;

    task automatic chk(input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s [%s] act=%0h exp=%0h", ph, what, act, exp);
        end
    endtask

    task automatic compare();
        bit m_req;
        m_req = m_busy && (m_q.size() < DEPTH);
        chk("busy R3", busy, m_busy);
        chk("cmd_acc R3", cmd_acc, m_busy);
        chk("cmd_err R8", cmd_err, m_err);
        chk("fl_req R4 R9", fl_req, m_req);
        chk("rx_level R5 R6 R10", rx_level, m_q.size());
        chk("fl_target R2", {fl_addr, fl_dev, fl_mode}, m_xt);
        if (m_q.size() > 0) chk("pop_data R4 R10", pop_data, m_q[0]);
    endtask

    task automatic tick();
        bit m_req, take, clr_ok, pop_ok;
        @(negedge clk);
        cyc_n++;
        compare();
        m_req    = m_busy && (m_q.size() < DEPTH);
        fl_valid = m_req && !(stall && (cyc_n % 3 == 0));
        fl_data  = nxt_byte;
        tgt_wr = d_tgt; tgt_addr = d_addr; tgt_dev = d_dev; tgt_mode = d_mode;
        cmd_wr = d_cmd; cmd_len = LEN_W'(d_len); clr_wr = d_clr; pop = pop_hold;
        if (!rst_n) begin
            m_busy = 0; m_err = 0; m_remain = 0; m_q.delete();
            m_sh = '0; m_xt = '0;
        end else begin
            take   = fl_valid && m_req;
            clr_ok = d_clr && !m_busy;
            pop_ok = pop_hold && (m_q.size() > 0);
            if (clr_ok) m_q.delete();
            else begin
                if (pop_ok) void'(m_q.pop_front());
                if (take) begin m_q.push_back(nxt_byte); nxt_byte++; end
            end
            if (d_cmd) begin
                if (m_busy) m_err = 1;
                else if (d_len >= 1 && d_len <= MAX_LEN) begin
                    m_busy = 1; m_remain = d_len; m_xt = m_sh;
                end
            end
            if (take) begin
                m_remain--;
                if (m_remain == 0) m_busy = 0;
            end
            if (d_tgt) m_sh = {d_addr, d_dev, d_mode};
        end
        d_tgt = 0; d_cmd = 0; d_clr = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic set_tgt(input logic [23:0] a, input logic [1:0] dv, input logic [2:0] md);
        d_tgt = 1; d_addr = a; d_dev = dv; d_mode = md; tick();
    endtask

    task automatic launch(input int len);
        d_cmd = 1; d_len = len; tick();
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog expired act=running exp=done");
        finish_run();
    end

    initial begin
        ph = "R11"; ticks(3);            // reset state
        rst_n = 1'b1; ticks(2);
        ph = "R1"; set_tgt(24'h123456, 2'd1, 3'd5); ticks(4);
        ph = "R2 R4"; launch(5); ticks(8);
        ph = "R10"; pop_hold = 1; ticks(8); pop_hold = 0;   // includes empty pops
        ph = "R8"; set_tgt(24'h00ABCD, 2'd2, 3'd3);
        stall = 1; launch(20); ticks(2);
        launch(7); ticks(1);                               // ignored, sets error
        ph = "R2"; set_tgt(24'h777777, 2'd3, 3'd7); ticks(2);
        ph = "R6"; d_clr = 1; tick(); ticks(30);
        ph = "R5"; d_clr = 1; tick(); ticks(2);
        stall = 0; launch(3); ticks(5);
        d_clr = 1; pop_hold = 1; tick(); pop_hold = 0; ticks(2);
        ph = "R7"; launch(0); ticks(3); launch(65); ticks(3);
        ph = "R9"; launch(10); ticks(14);
        launch(64); ticks(70);                             // pauses at DEPTH
        pop_hold = 1; ticks(90); pop_hold = 0; ticks(3);
        finish_run();
    end
endmodule